// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a synchronous burst memory. A start address is captured from the address input on a rising clock edge whenever either of two strobes is high. One strobe belongs to the processor side and the other to the memory controller side. After that capture, the two least significant address bits step through a four-beat burst. They step once for each clock edge at which the advance input is high. The upper address bits stay exactly as captured.

A mode input selects between two burst orders. In counting order the low bits run up modulo four from the start value. In interleaved order the low bits are the start value XORed with the beat index. Bursting is optional: a new start address may be captured on every edge, and each capture restarts the burst at beat zero. The current address and the beat index are registered state, so they hold their values while the clock is stopped.

Top module: `burst_seq`

## Requirements
- R1: While rst_n is low at a rising edge, the sequencer clears itself, so addr_out and beat_idx are 0 after that edge.
- R2: A high level on either strobe_cpu or strobe_ctl at an edge captures addr_in. After that edge addr_out equals addr_in and beat_idx is 0.
- R3: If both strobes are high, or if a strobe and advance are high together, exactly one capture takes place. The result is identical to R2, and advance has no effect in that cycle.
- R4: With both strobes low and advance high, beat_idx increments by one per edge and wraps from 3 to 0.
- R5: With both strobes and advance low, beat_idx and addr_out keep their values at the edge and addr_in is ignored, as long as order_lin is unchanged.
- R6: With order_lin = 1 (counting order), addr_out[1:0] = (start[1:0] + beat_idx) mod 4.
- R7: With order_lin = 0 (interleaved order, the tie-off setting), addr_out[1:0] = start[1:0] XOR beat_idx.
- R8: addr_out[AW-1:2] never changes without a capture, including across the wrap of the low bits.
- R9: Captures on consecutive edges each take effect, and every capture restarts the burst at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_cpu | input | 1 | Processor-side address strobe |
| strobe_ctl | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step the burst by one beat |
| order_lin | input | 1 | 1 = counting order, 0 = interleaved order |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current burst address |
| beat_idx | output | 2 | Beat index within the burst |

## Verification
Every capture, step, hold and reset becomes visible at the outputs directly after the rising edge at which it is sampled. There is no further latency, because addr_out is decoded combinationally from the registered start address, beat index and order_lin. The bench therefore changes the inputs just after a falling edge and compares the outputs at the next falling edge, half a period after the sampling edge. A change of order_lin alone alters addr_out without waiting for an edge, and one table row relies on exactly that.

// File: rtl/burst_seq_pkg.sv
// Package: shared burst order encoding and the low-bit mapping function.
// Assumes: a burst length that is a power of two, so the mapping wraps naturally.
package burst_seq_pkg;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;

    // Map a start offset and a beat index to the offset presented for that beat.
    function automatic logic [1:0] map_offset(input logic [1:0] start,
                                              input logic [1:0] beat,
                                              input burst_order_e ord);
        logic [1:0] r;
        if (ord == ORD_LINEAR) r = start + beat;
        else                   r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_load_ctrl.sv
// burst_load_ctrl: decodes the two strobes and advance into one capture
// and one step command per cycle.
// Assumes: the inputs are synchronous to clk; a capture always beats a step.
module burst_load_ctrl (
    input  logic strobe_cpu,
    input  logic strobe_ctl,
    input  logic advance,
    output logic load,
    output logic step
);

    // Merge the strobes and suppress the step whenever a capture takes place.
    always_comb begin
        load = strobe_cpu | strobe_ctl;
        step = advance & ~load;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// burst_beat_ctr: wrapping beat counter of BEAT_W bits.
// Assumes: load and step are never high together (burst_load_ctrl guarantees this).
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);

    logic [BEAT_W-1:0] beat_q;

    // Reset or capture clears the count; a step adds one modulo 2**BEAT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    beat_q <= '0;
        else if (load) beat_q <= '0;
        else if (step) beat_q <= beat_q + 1'b1;
    end

    assign beat = beat_q;

    // R4: a step moves the count forward by exactly one, wrapping at the top.
    a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));

    // R5: with no command the count does not move.
    a_r5_beat_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(beat_q));

    // R1: after a reset edge the count is zero.
    a_r1_beat_reset: assert property (@(posedge clk)
        !rst_n |=> beat_q == '0);

endmodule

// File: rtl/burst_base_reg.sv
// burst_base_reg: holds the captured start address of the current burst.
// Assumes: a capture is the only way the stored value changes, apart from reset.
module burst_base_reg #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] base
);

    logic [AW-1:0] base_q;

    // Capture the external address on a strobe; otherwise keep the value.
    always_ff @(posedge clk) begin
        if (!rst_n)    base_q <= '0;
        else if (load) base_q <= addr_in;
    end

    assign base = base_q;

    // R2: a capture stores the address that was present at the edge.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> base_q == $past(addr_in));

    // R8: without a capture the stored start address stays untouched.
    a_r8_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_q));

endmodule

// File: rtl/burst_order_map.sv
// burst_order_map: forms the output address from the start address and the beat.
// Assumes: AW > BEAT_W; only the low BEAT_W bits depend on the beat index.
module burst_order_map #(
    parameter int AW     = 19,
    parameter int BEAT_W = 2
) (
    input  logic [AW-1:0]     base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_lin,
    output logic [AW-1:0]     addr
);
    import burst_seq_pkg::*;

    localparam int UPPER_W = AW - BEAT_W;

    logic [BEAT_W-1:0] offs;

    generate
        if (BEAT_W == 2) begin : g_pkg_map
            // Use the shared two-bit mapping for the standard four-beat burst.
            always_comb offs = map_offset(base[1:0], beat,
                                          burst_order_e'(order_lin));
        end else begin : g_wide_map
            // For other burst lengths, add or XOR over the whole offset field.
            always_comb offs = order_lin ? base[BEAT_W-1:0] + beat
                                         : base[BEAT_W-1:0] ^ beat;
        end
    endgenerate

    // Join the unchanged upper field with the mapped offset.
    always_comb addr = {base[AW-1:BEAT_W], offs};

    // R8: the upper field always comes straight from the start address.
    always_comb begin
        a_r8_upper_passthru: assert (addr[AW-1:BEAT_W] == base[AW-1 -: UPPER_W]);
    end

endmodule

// File: rtl/burst_seq.sv
// burst_seq: top of the burst address sequencer. Captures a start address on
// either strobe, steps a four-beat burst on advance, in counting or interleaved order.
// Assumes: all inputs are synchronous to clk; order_lin is tied low when unused.
module burst_seq #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_cpu,
    input  logic          strobe_ctl,
    input  logic          advance,
    input  logic          order_lin,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out,
    output logic [1:0]    beat_idx
);

    localparam int BEAT_W = 2;

    logic          load;
    logic          step;
    logic [AW-1:0] base;

    burst_load_ctrl u_ctrl (
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .advance    (advance),
        .load       (load),
        .step       (step)
    );

    burst_base_reg #(.AW(AW)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .base    (base)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .beat  (beat_idx)
    );

    burst_order_map #(.AW(AW), .BEAT_W(BEAT_W)) u_map (
        .base      (base),
        .beat      (beat_idx),
        .order_lin (order_lin),
        .addr      (addr_out)
    );

    // R2 / R3: any strobe, even together with advance, gives the captured address at beat 0.
    a_r3_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu || strobe_ctl) |=>
            (beat_idx == 2'd0 && base == $past(addr_in)));

    // R5: an idle cycle with a steady order_lin leaves the output address unchanged.
    a_r5_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu && !strobe_ctl && !advance) |=>
            (order_lin != $past(order_lin)) || $stable(addr_out));

    // R8: no strobe means the upper output bits are unchanged.
    a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu && !strobe_ctl) |=> $stable(addr_out[AW-1:2]));

endmodule

// File: tb/test_burst_seq.sv
// Bench: table-driven stimulus followed by directed reset checks.
module test_burst_seq;

    localparam int AW = 19;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_cpu = 1'b0;
    logic          strobe_ctl = 1'b0;
    logic          advance = 1'b0;
    logic          order_lin = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    burst_seq #(.AW(AW)) i_burst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .advance    (advance),
        .order_lin  (order_lin),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .beat_idx   (beat_idx)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Row fields: {cpu, ctl, adv, lin}, addr_in, expected addr_out, expected beat, requirement number.
    localparam logic [47:0] VEC [NV] = '{
        {4'b1001, 19'h12345, 19'h12345, 2'd0, 4'd2},  // R2 cpu capture
        {4'b0011, 19'h00000, 19'h12346, 2'd1, 4'd6},  // R6 counting beat 1
        {4'b0011, 19'h00000, 19'h12347, 2'd2, 4'd6},  // R6
        {4'b0011, 19'h00000, 19'h12344, 2'd3, 4'd8},  // R8 low bits wrap, upper kept
        {4'b0001, 19'h00000, 19'h12344, 2'd3, 4'd5},  // R5 hold, addr_in ignored
        {4'b0011, 19'h00000, 19'h12345, 2'd0, 4'd4},  // R4 beat wraps 3 -> 0
        {4'b0100, 19'h0ABCE, 19'h0ABCE, 2'd0, 4'd2},  // R2 ctl capture
        {4'b0010, 19'h00000, 19'h0ABCF, 2'd1, 4'd7},  // R7 interleaved
        {4'b0010, 19'h00000, 19'h0ABCC, 2'd2, 4'd7},  // R7
        {4'b0010, 19'h00000, 19'h0ABCD, 2'd3, 4'd7},  // R7
        {4'b1110, 19'h7FFFF, 19'h7FFFF, 2'd0, 4'd3},  // R3 both strobes plus advance
        {4'b0010, 19'h00000, 19'h7FFFE, 2'd1, 4'd7},  // R7
        {4'b0011, 19'h00000, 19'h7FFFD, 2'd2, 4'd6},  // R6 order switched mid-burst
        {4'b1011, 19'h00003, 19'h00003, 2'd0, 4'd3},  // R3 capture beats advance
        {4'b0101, 19'h00010, 19'h00010, 2'd0, 4'd9},  // R9 back-to-back captures
        {4'b1001, 19'h40002, 19'h40002, 2'd0, 4'd9},  // R9
        {4'b0011, 19'h00000, 19'h40003, 2'd1, 4'd6},  // R6
        {4'b0001, 19'h11111, 19'h40003, 2'd1, 4'd5}   // R5
    };

    task automatic check(input string req, input logic [AW-1:0] exp_a,
                         input logic [1:0] exp_b);
        total++;
        if (addr_out !== exp_a || beat_idx !== exp_b) begin
            bad++;
            $display("FAIL %s: addr_out=%h beat_idx=%0d expected addr_out=%h beat_idx=%0d",
                     req, addr_out, beat_idx, exp_a, exp_b);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", '0, 2'd0);                 // R1 state after the first reset
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {strobe_cpu, strobe_ctl, advance, order_lin} = VEC[i][47:44];
            addr_in = VEC[i][43:25];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VEC[i][3:0], i), VEC[i][24:6], VEC[i][5:4]);
        end
        // R1: a reset in the middle of a burst clears everything.
        {strobe_cpu, strobe_ctl, advance, order_lin} = 4'b0011;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 mid-burst", '0, 2'd0);
        // R1: reset wins over a strobe that arrives at the same time.
        strobe_cpu = 1'b1; addr_in = 19'h55555;
        @(posedge clk); @(negedge clk);
        check("R1 over strobe", '0, 2'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 after reset", 19'h55555, 2'd0);
        // R7: tied-low order after reset, start offset 01.
        strobe_cpu = 1'b0; order_lin = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 after reset", 19'h55554, 2'd1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule